// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two 32-bit operands and a carry-in with no clock. The word is cut into four 8-bit groups. Inside a group, the carry into every bit position is a flat sum of products. Each product is built from the per-bit generate term (both operand bits set), the per-bit propagate term (either operand bit set) and the group's carry-in. No internal carry waits on another one. The carry-out of each group is also written as a flat expression, and it feeds the carry-in of the next group. Across the four groups the carries therefore ripple.

The block sits on the critical path of an arithmetic unit. It brings out the carry into the most significant bit next to the final carry-out, so the surrounding logic can form signed overflow as the XOR of the two. It does not handle subtraction control, the signed versus unsigned choice or pipelining. A caller subtracts by inverting one operand and driving the carry-in high.

Top module: `gla_adder`

## Requirements
- R1: `sum` equals the low 32 bits of `op_a + op_b + carry_in`, both operands taken unsigned.
- R2: `carry_out` equals bit 32 of the full 33-bit result of `op_a + op_b + carry_in`.
- R3: `carry_msb` equals the carry into bit 31, which is bit 31 of `op_a[30:0] + op_b[30:0] + carry_in`. As a result, `carry_msb XOR carry_out` is 1 exactly when the operands share a sign and `sum[31]` has the other sign.
- R4: A carry produced in one group reaches the next group. For example, 0x000000FF + 0x00000001 gives 0x00000100, and 0x00FFFFFF + 0x00000001 gives 0x01000000.
- R5: A carry-in of 1 with every bit propagating runs through all four groups. 0xFFFFFFFF + 0x00000000 + 1 gives `sum` 0 with `carry_out` 1 and `carry_msb` 1.
- R6: With zero operands and a carry-in of 0, every output is 0. With zero operands and a carry-in of 1, `sum` is 1 and both carry outputs are 0.
- R7: The block is combinational. The outputs follow a change of inputs without any clock edge.
- R8: With the same operands, moving the carry-in from 0 to 1 raises the result by exactly one, modulo 2^33.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | first addend |
| op_b | input | 32 | second addend |
| carry_in | input | 1 | carry into bit 0 |
| sum | output | 32 | low 32 bits of the result |
| carry_out | output | 1 | carry out of bit 31 |
| carry_msb | output | 1 | carry into bit 31 |

## Verification
Whenever the inputs settle, the embedded assertions compare every group's outputs, and the whole word, against a behavioural addition. They also check that each flat carry-out agrees with the chained form through the group's top bit, and that the XOR of the two carries matches signed overflow taken from the operand and result signs. The bench shows the effects that depend on chosen operand patterns: a carry crossing each group boundary, the full-length propagate path, the zero and carry-in-only cases, the one-step effect of the carry-in, and outputs that settle with no clock.

// File: rtl/gla_pkg.sv
package gla_pkg;
   localparam int unsigned GLA_DEF_WIDTH   = 32;
   localparam int unsigned GLA_DEF_GROUP_W = 8;

   typedef struct packed {
      logic gen;
      logic prop;
      logic half;
   } gla_bit_t;
endpackage

// File: rtl/gla_bit_pg.sv
module gla_bit_pg
   import gla_pkg::*;
(
   input  logic     a_bit,
   input  logic     b_bit,
   output gla_bit_t terms
);
   always_comb begin
      terms.gen  = a_bit & b_bit;
      terms.prop = a_bit | b_bit;
      terms.half = a_bit ^ b_bit;
   end
endmodule

// File: rtl/gla_group.sv
module gla_group
   import gla_pkg::*;
#(
   parameter int unsigned GROUP_W = GLA_DEF_GROUP_W
) (
   input  logic [GROUP_W-1:0] grp_a,
   input  logic [GROUP_W-1:0] grp_b,
   input  logic               grp_cin,
   output logic [GROUP_W-1:0] grp_sum,
   output logic [GROUP_W-1:0] grp_carry,
   output logic               grp_cout
);
   initial begin
      if (GROUP_W < 1 || GROUP_W > 16)
         $error("gla_group: GROUP_W must lie in 1..16");
   end

   gla_bit_t [GROUP_W-1:0] bt;
   logic     [GROUP_W-1:0] g_v, p_v, x_v;

   for (genvar i = 0; i < GROUP_W; i++) begin : g_bit
      gla_bit_pg u_pg (.a_bit(grp_a[i]), .b_bit(grp_b[i]), .terms(bt[i]));
      assign g_v[i] = bt[i].gen;
      assign p_v[i] = bt[i].prop;
      assign x_v[i] = bt[i].half;
   end

   // Flat lookahead: carry into position k is an OR of products, none using another carry.
   function automatic logic look(input logic [GROUP_W-1:0] g, input logic [GROUP_W-1:0] p,
                                 input logic c0, input int unsigned k);
      logic acc;
      logic term;
      acc = 1'b0;
      for (int unsigned j = 0; j < k; j++) begin
         term = g[j];
         for (int unsigned m = j + 1; m < k; m++) term = term & p[m];
         acc = acc | term;
      end
      term = c0;
      for (int unsigned m = 0; m < k; m++) term = term & p[m];
      return acc | term;
   endfunction

   always_comb begin
      for (int unsigned k = 0; k < GROUP_W; k++) grp_carry[k] = look(g_v, p_v, grp_cin, k);
      grp_cout = look(g_v, p_v, grp_cin, GROUP_W);
      grp_sum  = x_v ^ grp_carry;
   end

   always_comb begin
      p_cout_chain_r2: assert (grp_cout ==
                               (g_v[GROUP_W-1] | (p_v[GROUP_W-1] & grp_carry[GROUP_W-1])))
         else $error("flat group carry-out disagrees with chained form");
      p_grp_sum_r1: assert ({grp_cout, grp_sum} ==
                            ({1'b0, grp_a} + {1'b0, grp_b} + {{GROUP_W{1'b0}}, grp_cin}))
         else $error("group result differs from behavioural addition");
   end
endmodule

// File: rtl/gla_adder.sv
module gla_adder
   import gla_pkg::*;
#(
   parameter int unsigned WIDTH   = GLA_DEF_WIDTH,
   parameter int unsigned GROUP_W = GLA_DEF_GROUP_W
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out,
   output logic             carry_msb
);
   localparam int unsigned NGRP = WIDTH / GROUP_W;

   initial begin
      if (WIDTH < 2 || (WIDTH % GROUP_W) != 0)
         $error("gla_adder: WIDTH must be at least 2 and a multiple of GROUP_W");
   end

   logic [NGRP:0]      link;
   logic [WIDTH-1:0]   bit_carry;

   assign link[0] = carry_in;

   for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
      gla_group #(.GROUP_W(GROUP_W)) u_grp (
         .grp_a    (op_a[gi*GROUP_W +: GROUP_W]),
         .grp_b    (op_b[gi*GROUP_W +: GROUP_W]),
         .grp_cin  (link[gi]),
         .grp_sum  (sum[gi*GROUP_W +: GROUP_W]),
         .grp_carry(bit_carry[gi*GROUP_W +: GROUP_W]),
         .grp_cout (link[gi+1])
      );
   end

   assign carry_out = link[NGRP];
   assign carry_msb = bit_carry[WIDTH-1];

   always_comb begin
      p_word_sum_r1: assert ({carry_out, sum} ==
                             ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
         else $error("word result differs from behavioural addition");
      p_overflow_r3: assert ((carry_msb ^ carry_out) ==
                             ((op_a[WIDTH-1] == op_b[WIDTH-1]) && (sum[WIDTH-1] != op_a[WIDTH-1])))
         else $error("carry pair does not match signed overflow");
   end
endmodule

// File: tb/gla_adder_bench.sv
module gla_adder_bench;
   logic        clk = 1'b0;
   logic [31:0] op_a, op_b;
   logic        carry_in;
   logic [31:0] sum;
   logic        carry_out, carry_msb;
   int          n_chk = 0, n_bad = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   gla_adder u_gla_adder (.op_a(op_a), .op_b(op_b), .carry_in(carry_in),
                          .sum(sum), .carry_out(carry_out), .carry_msb(carry_msb));

   typedef struct packed { logic [31:0] a; logic [31:0] b; logic ci; } vec_t;
   localparam vec_t VECS [12] = '{
      '{32'h0000_0000, 32'h0000_0000, 1'b0},
      '{32'h0000_0000, 32'h0000_0000, 1'b1},
      '{32'h0000_00FF, 32'h0000_0001, 1'b0},
      '{32'h0000_FFFF, 32'h0000_0001, 1'b0},
      '{32'h00FF_FFFF, 32'h0000_0001, 1'b0},
      '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
      '{32'h7FFF_FFFF, 32'h0000_0001, 1'b0},
      '{32'h8000_0000, 32'h8000_0000, 1'b0},
      '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
      '{32'h1234_5678, 32'h8765_4321, 1'b1},
      '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1},
      '{32'h0F0F_0F0F, 32'h0F0F_0F0F, 1'b0}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h (a=%h b=%h ci=%b)", req, act, exp, op_a, op_b, carry_in);
      end
   endtask

   task automatic apply_and_check(input logic [31:0] a, input logic [31:0] b, input logic ci);
      logic [32:0] full;
      logic [31:0] low;
      @(negedge clk);
      op_a = a; op_b = b; carry_in = ci;
      #1;
      full = {1'b0, a} + {1'b0, b} + {32'd0, ci};
      low  = {1'b0, a[30:0]} + {1'b0, b[30:0]} + {31'd0, ci};
      check("R1 sum", {32'd0, sum}, {32'd0, full[31:0]});
      check("R2 carry_out", {63'd0, carry_out}, {63'd0, full[32]});
      check("R3 carry_msb", {63'd0, carry_msb}, {63'd0, low[31]});
   endtask

   initial begin
      op_a = '0; op_b = '0; carry_in = 1'b0;
      for (int i = 0; i < 12; i++) apply_and_check(VECS[i].a, VECS[i].b, VECS[i].ci);

      // R6: zero and carry-in-only
      apply_and_check(32'd0, 32'd0, 1'b0);
      check("R6 zero", {31'd0, carry_out, carry_msb, sum}, 64'd0);
      apply_and_check(32'd0, 32'd0, 1'b1);
      check("R6 cin only", {31'd0, carry_out, carry_msb, sum}, 64'd1);

      // R4: carry crosses each group boundary
      apply_and_check(32'h0000_00FF, 32'h0000_0001, 1'b0);
      check("R4 boundary 8", {32'd0, sum}, 64'h100);
      apply_and_check(32'h00FF_FFFF, 32'h0000_0001, 1'b0);
      check("R4 boundary 24", {32'd0, sum}, 64'h0100_0000);

      // R5: full propagate path
      apply_and_check(32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
      check("R5 propagate", {31'd0, carry_out, carry_msb, sum}, {31'd0, 1'b1, 1'b1, 32'd0});

      // R3: signed overflow via carry pair
      apply_and_check(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
      check("R3 ovf pos", {63'd0, carry_msb ^ carry_out}, 64'd1);
      apply_and_check(32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
      check("R3 ovf neg", {63'd0, carry_msb ^ carry_out}, 64'd1);
      apply_and_check(32'h7FFF_FFFF, 32'h8000_0000, 1'b1);
      check("R3 no ovf", {63'd0, carry_msb ^ carry_out}, 64'd0);

      // R7: no clock edge needed
      @(posedge clk); #1;
      op_a = 32'h0000_0010; op_b = 32'h0000_0020; carry_in = 1'b0;
      #1;
      check("R7 comb", {32'd0, sum}, 64'h30);

      // R8: carry-in adds exactly one
      for (int i = 0; i < 50; i++) begin
         logic [31:0] ra, rb;
         logic [32:0] r0;
         ra = $urandom; rb = $urandom;
         apply_and_check(ra, rb, 1'b0);
         r0 = {carry_out, sum};
         apply_and_check(ra, rb, 1'b1);
         check("R8 cin step", {31'd0, carry_out, sum}, {31'd0, r0 + 33'd1});
      end

      // R1/R2/R3 random sweep including group-wide propagate patterns
      for (int i = 0; i < 300; i++) begin
         logic [31:0] ra;
         ra = $urandom;
         apply_and_check(ra, (i % 3 == 0) ? ~ra : $urandom, 1'(i & 1));
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule